// File: doc/BRIEF.md
# Serial Synthesizer Control Interface

This block is the write-only, three-wire configuration port of a frequency synthesizer. A host drives a serial data line, a shift clock and a load strobe. All three pins are brought into the system clock domain by a synchronizer. On each synchronized rising edge of the shift clock, the data bit is captured into a word-wide shift register. The host sends each word most-significant position first, so the final bit it sends is a routing bit.

When the load strobe rises, the routing bit steers the whole word to one of two latch sets. One set is the reference configuration: a reference divide ratio plus four mode flags. The other set is the main-divider configuration: a swallow count and a program count. The loaded set gives a one-cycle update pulse, so downstream counters can restart from the new values. The latched values appear directly on the outputs.

Field widths are parameters. The word length is one routing bit plus the main-divider fields, and the reference fields must fill the same number of bits (REF_W + 4 == SWAL_W + PROG_W). With the defaults the word is 19 bits.

Top module: `synth_ctl_port`

## Requirements
- R1: After synchronous reset, the reference ratio is 3, the program count is 3, the swallow count is 0, all four mode flags are 0, and neither update pulse is high.
- R2: The shift register holds the last WORD_W bits captured on rising shift-clock edges. Counting positions from 1 at the last bit received, position 1 is the routing bit.
- R3: On a load with routing bit 1, the reference set takes its values from the word. Positions 2..REF_W+1 give the ratio, least significant bit at position 2. The next four positions give, in order: prescaler select (1 = 32/33 modulus, 0 = 64/65), phase inversion, monitor select, and pump-current select (1 = high current, 0 = low). The main-divider outputs do not change.
- R4: On a load with routing bit 0, the main-divider set takes its values from the word. Positions 2..SWAL_W+1 give the swallow count, and the following PROG_W positions give the program count; both fields are least significant bit first. The reference outputs do not change.
- R5: A latch set loads exactly once per rising transition of the load strobe, however long the strobe stays high.
- R6: Shift-clock edges that occur while the load strobe is high do not change the shift register.
- R7: Each load produces a pulse of exactly one system clock cycle on the update output of the selected set only. An output of a set changes only in a cycle in which that set's update pulse is high.
- R8: When more than WORD_W bits are shifted in before a load, only the last WORD_W bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_le_i | input | 1 | Load strobe (asynchronous) |
| ref_ratio_o | output | REF_W | Reference divide ratio |
| presc_sel_o | output | 1 | Prescaler modulus select, 1 = 32/33 |
| phase_inv_o | output | 1 | Phase comparator polarity |
| mon_sel_o | output | 1 | Monitor output select |
| pump_hi_o | output | 1 | Pump current select, 1 = high |
| ref_upd_o | output | 1 | One-cycle pulse when the reference set loads |
| swallow_o | output | SWAL_W | Swallow count |
| prog_o | output | PROG_W | Program count |
| div_upd_o | output | 1 | One-cycle pulse when the main-divider set loads |

## Verification
The bench builds the block with REF_W = 4, SWAL_W = 3 and PROG_W = 5, which gives a 9-bit word. At that size every one of the 512 words can be shifted in and loaded. This sweep covers every field pattern and both routing values, and it checks the unselected set against the bench's own model after each load. The small word also keeps the extra-bit, held-strobe and ignored-edge scenarios short, while the same field mapping is used at full width.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

    // Routing-bit values (position 1 of the word)
    typedef enum logic {
        DEST_DIV = 1'b0,
        DEST_REF = 1'b1
    } dest_e;

    // Mode flags, packed so that bit 0 sits at the lowest word position
    typedef struct packed {
        logic pump_hi;
        logic mon_sel;
        logic phase_inv;
        logic presc_sel;
    } mode_t;

    localparam int MODE_W      = $bits(mode_t);
    localparam int RATIO_RESET = 3;
    localparam int PROG_RESET  = 3;
    localparam int SWAL_RESET  = 0;

    function automatic dest_e route_of(input logic lsb);
        return lsb ? DEST_REF : DEST_DIV;
    endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] rise_o
);
    logic [STAGES-1:0][N-1:0] chain;
    logic [N-1:0]             prev;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= chain[STAGES-1];
    end

    assign sync_o = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst)     word_o <= '0;
        else if (en) word_o <= {word_o[W-2:0], din};
    end
endmodule

// File: rtl/sctl_bank.sv
module sctl_bank #(
    parameter int         W     = 18,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         upd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= RST_V;
            upd <= 1'b0;
        end else begin
            upd <= load;
            if (load) q <= d;
        end
    end
endmodule

// File: rtl/synth_ctl_port.sv
module synth_ctl_port
    import synth_ctl_pkg::*;
#(
    parameter int REF_W       = 14,
    parameter int SWAL_W      = 7,
    parameter int PROG_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_le_i,
    output logic [REF_W-1:0]  ref_ratio_o,
    output logic              presc_sel_o,
    output logic              phase_inv_o,
    output logic              mon_sel_o,
    output logic              pump_hi_o,
    output logic              ref_upd_o,
    output logic [SWAL_W-1:0] swallow_o,
    output logic [PROG_W-1:0] prog_o,
    output logic              div_upd_o
);
    localparam int WORD_W = 1 + SWAL_W + PROG_W;
    localparam int REFB_W = REF_W + MODE_W;
    localparam int DIVB_W = SWAL_W + PROG_W;
    localparam logic [REFB_W-1:0] REF_RST =
        {{MODE_W{1'b0}}, REF_W'(RATIO_RESET)};
    localparam logic [DIVB_W-1:0] DIV_RST =
        {PROG_W'(PROG_RESET), SWAL_W'(SWAL_RESET)};

    // pin order in vector: {le, dat, clk}
    logic [2:0]        pins_s, pins_r;
    logic [WORD_W-1:0] word;
    logic              shift_en, le_rise;
    dest_e             dest;
    logic [REFB_W-1:0] ref_q;
    logic [DIVB_W-1:0] div_q;
    mode_t             mode;

    sctl_sync #(.N(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_le_i, ser_dat_i, ser_clk_i}),
        .sync_o  (pins_s),
        .rise_o  (pins_r)
    );

    assign shift_en = pins_r[0] & ~pins_s[2];
    assign le_rise  = pins_r[2];

    sctl_shift #(.W(WORD_W)) i_shift (
        .clk    (clk),
        .rst    (rst),
        .en     (shift_en),
        .din    (pins_s[1]),
        .word_o (word)
    );

    assign dest = route_of(word[0]);

    sctl_bank #(.W(REFB_W), .RST_V(REF_RST)) i_ref_bank (
        .clk  (clk),
        .rst  (rst),
        .load (le_rise && dest == DEST_REF),
        .d    (word[REFB_W:1]),
        .q    (ref_q),
        .upd  (ref_upd_o)
    );

    sctl_bank #(.W(DIVB_W), .RST_V(DIV_RST)) i_div_bank (
        .clk  (clk),
        .rst  (rst),
        .load (le_rise && dest == DEST_DIV),
        .d    (word[DIVB_W:1]),
        .q    (div_q),
        .upd  (div_upd_o)
    );

    assign mode        = mode_t'(ref_q[REFB_W-1:REF_W]);
    assign ref_ratio_o = ref_q[REF_W-1:0];
    assign presc_sel_o = mode.presc_sel;
    assign phase_inv_o = mode.phase_inv;
    assign mon_sel_o   = mode.mon_sel;
    assign pump_hi_o   = mode.pump_hi;
    assign swallow_o   = div_q[SWAL_W-1:0];
    assign prog_o      = div_q[DIVB_W-1:SWAL_W];
endmodule

// File: rtl/sctl_chk.sv
module sctl_chk #(
    parameter int REF_W  = 14,
    parameter int SWAL_W = 7,
    parameter int PROG_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [REF_W-1:0]  ref_ratio_o,
    input logic              presc_sel_o,
    input logic              phase_inv_o,
    input logic              mon_sel_o,
    input logic              pump_hi_o,
    input logic              ref_upd_o,
    input logic [SWAL_W-1:0] swallow_o,
    input logic [PROG_W-1:0] prog_o,
    input logic              div_upd_o
);
    // R1
    rst_dflt_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ref_ratio_o == REF_W'(3) && prog_o == PROG_W'(3) &&
                        swallow_o == '0 && !presc_sel_o && !phase_inv_o &&
                        !mon_sel_o && !pump_hi_o && !ref_upd_o && !div_upd_o));

    // R7
    ref_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ref_upd_o |=> !ref_upd_o);

    // R7
    div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        div_upd_o |=> !div_upd_o);

    // R7
    upd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ref_upd_o && div_upd_o));

    // R4
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_upd_o |-> $stable({ref_ratio_o, presc_sel_o, phase_inv_o,
                                mon_sel_o, pump_hi_o}));

    // R3
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !div_upd_o |-> $stable({swallow_o, prog_o}));
endmodule

bind synth_ctl_port sctl_chk #(
    .REF_W  (REF_W),
    .SWAL_W (SWAL_W),
    .PROG_W (PROG_W)
) i_sctl_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_ratio_o (ref_ratio_o),
    .presc_sel_o (presc_sel_o),
    .phase_inv_o (phase_inv_o),
    .mon_sel_o   (mon_sel_o),
    .pump_hi_o   (pump_hi_o),
    .ref_upd_o   (ref_upd_o),
    .swallow_o   (swallow_o),
    .prog_o      (prog_o),
    .div_upd_o   (div_upd_o)
);

// File: tb/test_synth_ctl_port.sv
module test_synth_ctl_port;
    localparam int RW = 4, SW = 3, PW = 5;
    localparam int W  = 1 + SW + PW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic [RW-1:0] ref_ratio;
    logic presc, phinv, monsel, pumphi, ref_upd, div_upd;
    logic [SW-1:0] swal;
    logic [PW-1:0] prog;

    int checks = 0, errors = 0;
    int ref_pulses = 0, div_pulses = 0, wide_pulses = 0;
    logic prev_ref = 1'b0, prev_div = 1'b0;

    // expected model state
    logic [RW+3:0] exp_ref;
    logic [SW+PW-1:0] exp_div;

    always #10 clk = ~clk;

    synth_ctl_port #(.REF_W(RW), .SWAL_W(SW), .PROG_W(PW)) i_synth_ctl_port (
        .clk(clk), .rst(rst),
        .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
        .ref_ratio_o(ref_ratio), .presc_sel_o(presc), .phase_inv_o(phinv),
        .mon_sel_o(monsel), .pump_hi_o(pumphi), .ref_upd_o(ref_upd),
        .swallow_o(swal), .prog_o(prog), .div_upd_o(div_upd)
    );

    always @(negedge clk) begin
        if (ref_upd) ref_pulses++;
        if (div_upd) div_pulses++;
        if ((ref_upd && prev_ref) || (div_upd && prev_div)) wide_pulses++;
        prev_ref = ref_upd;
        prev_div = div_upd;
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = bits[i];
            wait_n(4);
            sclk = 1'b1;
            wait_n(4);
            sclk = 1'b0;
        end
    endtask

    task automatic pulse_le(input int hold);
        sle = 1'b1;
        wait_n(hold);
        sle = 1'b0;
        wait_n(6);
    endtask

    task automatic model_load(input logic [W-1:0] w);
        if (w[0]) exp_ref = w[RW+4:1];
        else      exp_div = w[SW+PW:1];
    endtask

    task automatic compare_all(input string req);
        check({req, " ratio"},   32'(ref_ratio), 32'(exp_ref[RW-1:0]));
        check({req, " modes"},   32'({pumphi, monsel, phinv, presc}),
                                 32'(exp_ref[RW+3:RW]));
        check({req, " swallow"}, 32'(swal), 32'(exp_div[SW-1:0]));
        check({req, " prog"},    32'(prog), 32'(exp_div[SW+PW-1:SW]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        exp_ref = {4'b0, RW'(3)};
        exp_div = {PW'(3), SW'(0)};
        wait_n(4);
        rst = 1'b0;
        wait_n(3);
        // R1 reset state
        compare_all("R1");
        check("R1 upd", 32'({ref_upd, div_upd}), 32'd0);

        // R2 R3 R4: exhaustive sweep of every word
        for (int w = 0; w < (1 << W); w++) begin
            int r0, d0;
            r0 = ref_pulses;
            d0 = div_pulses;
            shift_bits(32'(w), W);
            pulse_le(8);
            model_load(W'(w));
            compare_all(w[0] ? "R3" : "R4");
            check("R7 ref pulse count", 32'(ref_pulses - r0), 32'(w[0]));
            check("R7 div pulse count", 32'(div_pulses - d0), 32'(!w[0]));
        end

        // R8: extra leading bits are discarded
        begin
            logic [W-1:0] w8;
            w8 = W'(9'h1A5);
            shift_bits({20'h0, 3'b101, w8}, W + 3);
            pulse_le(8);
            model_load(w8);
            compare_all("R8");
        end

        // R5: strobe held high for a long time loads once
        begin
            int r0;
            logic [W-1:0] w5;
            w5 = W'(9'h0B3);
            r0 = ref_pulses;
            shift_bits(32'(w5), W);
            pulse_le(60);
            model_load(w5);
            check("R5 single load", 32'(ref_pulses - r0), 32'd1);
            compare_all("R5");
        end

        // R6: shift edges during a high strobe are ignored
        begin
            int d0;
            logic [W-1:0] w6;
            w6 = W'(9'h0CE);
            shift_bits(32'(w6), W);
            sle = 1'b1;
            wait_n(6);
            shift_bits(32'(~w6), W);
            sle = 1'b0;
            wait_n(6);
            model_load(w6);
            compare_all("R6 first");
            d0 = div_pulses;
            pulse_le(8);
            check("R6 reload pulse", 32'(div_pulses - d0), 32'd1);
            compare_all("R6 reload");
        end

        // R7: every pulse was one cycle wide
        check("R7 pulse width", 32'(wide_pulses), 32'd0);
        summary();
    end
endmodule